// File: doc/BRIEF.md
# Multi-Input Flush Coordinator

This block sits between several request/acknowledge input channels, several request/acknowledge output channels and a small compute stage. Each input bus carries a data word plus one extra most-significant bit; when that bit is set the transfer is a flush token rather than data. The block works out, for every input, whether it holds valid data, holds a pending flush token, or is idle. It then drives the input acknowledge registers so that a flush token is only ever taken when every input presents one. The tokens on all inputs are then taken in the same cycle.

While only some inputs hold a flush token, the inputs that carry ordinary data are drained, which discards their data. The flush tokens stay pending until the missing inputs catch up. Output channels drop their request once the receiver acknowledges it. The compute stage is a stub. When every input holds data, no input is flushing and every output is free, it takes one word from each input and offers the combined word on every output. The combining operation is chosen by a parameter: a sum modulo 2^W, or a bitwise XOR.

Top module: `flush_coord`

## Requirements
- R1: An input whose flush bit (bit W of its bus) is set never counts as holding data, so the compute stage never fires on a flush token.
- R2: Reset (synchronous, active high) sets every input acknowledge to 1 and clears every output request to 0.
- R3: When every input is flushing, meaning raw request high, flush bit set and acknowledge low, all input acknowledges go high together on the next clock edge.
- R4: When no input is flushing, an input whose raw request is low and whose acknowledge is high clears its acknowledge on the next edge. An acknowledge stays high while its raw request stays high.
- R5: When some but not all inputs are flushing, an input holding data with its acknowledge low has its acknowledge set, which drains the data. A flushing input keeps its acknowledge low.
- R6: When some but not all inputs are flushing, an input with no data and its acknowledge high clears its acknowledge.
- R7: An output whose request and acknowledge are both high clears its request on the next edge, independently of the other outputs.
- R8: When no input is flushing, every input holds data with its acknowledge low, and every output request is low, the stage sets all input acknowledges and all output requests. Each output word is the sum of the input words modulo 2^W (default variant).
- R9: While any output request is still high, the compute stage does not fire, and input data stays unacknowledged.
- R10: A flush token is never consumed on one input without the flush tokens on all inputs being consumed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | N_IN | Raw request per input channel |
| in_bus | input | N_IN*(W+1) | Input buses, channel i at bits i*(W+1) upward; bit W of each is the flush marker |
| in_ack | output | N_IN | Registered acknowledge per input channel |
| out_req | output | N_OUT | Registered request per output channel |
| out_word | output | N_OUT*W | Output words, channel j at bits j*W upward |
| out_ack | input | N_OUT | Acknowledge per output channel |

## Verification
The coordinator is driven with all-data rounds, all-flush rounds, flush tokens that arrive on one input while another carries data and a third is idle, and data offered while an output is still occupied. All-flush and all-data rounds show that a flush token is never mistaken for data. The staggered flush pattern shows draining apart from holding: the data input must be acknowledged, the flushing input must wait, and the late input must release everything at once. A scoreboard watches every acknowledge rise on a flushing input and confirms that the whole set of inputs was flushing and released in that same cycle. The backpressure round acknowledges one output at a time to show that outputs clear independently.

// File: rtl/flush_coord_pkg.sv
package flush_coord_pkg;
   // Summary of the flush state across all inputs
   typedef enum logic [1:0] {
      FM_NONE = 2'd0,   // no input holds a pending flush token
      FM_SOME = 2'd1,   // at least one, but not every, input is flushing
      FM_ALL  = 2'd2    // every input is flushing
   } flush_mode_e;

   // Combining operation of the compute stub
   localparam int unsigned COMB_SUM = 0;
   localparam int unsigned COMB_XOR = 1;
endpackage

// File: rtl/fc_classify.sv
module fc_classify #(
   parameter int unsigned N_IN = 3,
   parameter int unsigned W    = 8
) (
   input  logic [N_IN-1:0]          in_req,
   input  logic [N_IN*(W+1)-1:0]    in_bus,
   input  logic [N_IN-1:0]          in_ack,
   output logic [N_IN-1:0]          eff_req,
   output logic [N_IN-1:0]          flushing,
   output logic [N_IN-1:0]          full,
   output logic [N_IN*W-1:0]        words
);
   localparam int unsigned LANE = W + 1;

   for (genvar i = 0; i < N_IN; i++) begin : g_lane
      logic mark;
      assign mark              = in_bus[i*LANE + W];
      assign words[i*W +: W]   = in_bus[i*LANE +: W];
      assign eff_req[i]        = in_req[i] & ~mark;
      assign flushing[i]       = in_req[i] & mark & ~in_ack[i];
      assign full[i]           = eff_req[i] & ~in_ack[i];
   end
endmodule

// File: rtl/fc_mode.sv
module fc_mode
   import flush_coord_pkg::*;
#(
   parameter int unsigned N_IN = 3
) (
   input  logic [N_IN-1:0] flushing,
   output flush_mode_e     mode
);
   always_comb begin
      if (&flushing)       mode = FM_ALL;
      else if (|flushing)  mode = FM_SOME;
      else                 mode = FM_NONE;
   end
endmodule

// File: rtl/fc_in_ack.sv
module fc_in_ack
   import flush_coord_pkg::*;
#(
   parameter int unsigned N_IN = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  flush_mode_e     mode,
   input  logic [N_IN-1:0] in_req,
   input  logic [N_IN-1:0] eff_req,
   input  logic [N_IN-1:0] flushing,
   input  logic            take,
   output logic [N_IN-1:0] in_ack
);
   for (genvar i = 0; i < N_IN; i++) begin : g_ack
      always_ff @(posedge clk) begin
         if (rst) begin
            in_ack[i] <= 1'b1;
         end else begin
            unique case (mode)
               FM_ALL: in_ack[i] <= 1'b1;
               FM_SOME: begin
                  if (!eff_req[i] && in_ack[i])      in_ack[i] <= 1'b0;
                  else if (eff_req[i] && !in_ack[i]) in_ack[i] <= 1'b1;
               end
               default: begin
                  if (take)                          in_ack[i] <= 1'b1;
                  else if (!in_req[i] && in_ack[i])  in_ack[i] <= 1'b0;
               end
            endcase
         end
      end

      // R5: a draining data input gets its acknowledge
      p_drain_data_r5: assert property (@(posedge clk) disable iff (rst)
         (mode == FM_SOME && eff_req[i] && !in_ack[i]) |=> in_ack[i]);

      // R5: a flushing input is held while the flush is partial
      p_hold_partial_r5: assert property (@(posedge clk) disable iff (rst)
         (mode == FM_SOME && flushing[i]) |=> !in_ack[i]);

      // R10: a flushing input is only released when all inputs flush
      p_no_lone_flush_r10: assert property (@(posedge clk) disable iff (rst)
         ($rose(in_ack[i]) && $past(flushing[i])) |-> $past(mode == FM_ALL));
   end

   // R3: every input released together
   p_all_release_r3: assert property (@(posedge clk) disable iff (rst)
      (mode == FM_ALL) |=> (&in_ack));

   // R2: acknowledges come out of reset high
   p_reset_ack_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (&in_ack));
endmodule

// File: rtl/fc_out_req.sv
module fc_out_req #(
   parameter int unsigned N_OUT = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fill,
   input  logic [N_OUT-1:0] out_ack,
   output logic [N_OUT-1:0] out_req
);
   for (genvar j = 0; j < N_OUT; j++) begin : g_req
      always_ff @(posedge clk) begin
         if (rst)                          out_req[j] <= 1'b0;
         else if (fill)                    out_req[j] <= 1'b1;
         else if (out_req[j] && out_ack[j]) out_req[j] <= 1'b0;
      end

      // R7: acknowledged output clears
      p_out_clear_r7: assert property (@(posedge clk) disable iff (rst)
         (out_req[j] && out_ack[j]) |=> !out_req[j]);
   end

   // R8: a fill raises every output
   p_fill_all_r8: assert property (@(posedge clk) disable iff (rst)
      fill |=> (&out_req));

   // R2: outputs idle out of reset
   p_reset_out_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (out_req == '0));
endmodule

// File: rtl/fc_stub.sv
module fc_stub
   import flush_coord_pkg::*;
#(
   parameter int unsigned N_IN    = 3,
   parameter int unsigned N_OUT   = 2,
   parameter int unsigned W       = 8,
   parameter int unsigned COMBINE = COMB_SUM
) (
   input  logic             clk,
   input  logic             rst,
   input  flush_mode_e      mode,
   input  logic [N_IN-1:0]  full,
   input  logic [N_IN*W-1:0] words,
   input  logic [N_OUT-1:0] out_req,
   output logic             fire,
   output logic [N_OUT*W-1:0] out_word
);
   logic [W-1:0] acc;

   if (COMBINE == COMB_XOR) begin : g_xor
      always_comb begin
         acc = '0;
         for (int i = 0; i < N_IN; i++) acc = acc ^ words[i*W +: W];
      end
   end else begin : g_sum
      always_comb begin
         acc = '0;
         for (int i = 0; i < N_IN; i++) acc = acc + words[i*W +: W];
      end
   end

   assign fire = (mode == FM_NONE) && (&full) && !(|out_req);

   for (genvar j = 0; j < N_OUT; j++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)       out_word[j*W +: W] <= '0;
         else if (fire) out_word[j*W +: W] <= acc;
      end
   end

   // R9: no fire while any output is occupied
   p_wait_out_r9: assert property (@(posedge clk) disable iff (rst)
      (|out_req) |-> !fire);

   // R1: a flushing state never lets the stage fire
   p_flush_not_data_r1: assert property (@(posedge clk) disable iff (rst)
      (mode != FM_NONE) |-> !fire);
endmodule

// File: rtl/flush_coord.sv
module flush_coord
   import flush_coord_pkg::*;
#(
   parameter int unsigned N_IN    = 3,
   parameter int unsigned N_OUT   = 2,
   parameter int unsigned W       = 8,
   parameter int unsigned COMBINE = COMB_SUM
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [N_IN-1:0]        in_req,
   input  logic [N_IN*(W+1)-1:0]  in_bus,
   output logic [N_IN-1:0]        in_ack,
   output logic [N_OUT-1:0]       out_req,
   output logic [N_OUT*W-1:0]     out_word,
   input  logic [N_OUT-1:0]       out_ack
);
   if (N_IN < 1)    begin : g_bad_nin   $error("N_IN must be at least 1");  end
   if (N_OUT < 1)   begin : g_bad_nout  $error("N_OUT must be at least 1"); end
   if (W < 1)       begin : g_bad_w     $error("W must be at least 1");     end
   if (COMBINE > 1) begin : g_bad_comb  $error("COMBINE must be 0 or 1");   end

   logic [N_IN-1:0]   eff_req;
   logic [N_IN-1:0]   flushing;
   logic [N_IN-1:0]   full;
   logic [N_IN*W-1:0] words;
   flush_mode_e       mode;
   logic              fire;

   fc_classify #(.N_IN(N_IN), .W(W)) u_class (
      .in_req  (in_req),
      .in_bus  (in_bus),
      .in_ack  (in_ack),
      .eff_req (eff_req),
      .flushing(flushing),
      .full    (full),
      .words   (words)
   );

   fc_mode #(.N_IN(N_IN)) u_mode (
      .flushing(flushing),
      .mode    (mode)
   );

   fc_stub #(.N_IN(N_IN), .N_OUT(N_OUT), .W(W), .COMBINE(COMBINE)) u_stub (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode),
      .full    (full),
      .words   (words),
      .out_req (out_req),
      .fire    (fire),
      .out_word(out_word)
   );

   fc_in_ack #(.N_IN(N_IN)) u_in_ack (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode),
      .in_req  (in_req),
      .eff_req (eff_req),
      .flushing(flushing),
      .take    (fire),
      .in_ack  (in_ack)
   );

   fc_out_req #(.N_OUT(N_OUT)) u_out_req (
      .clk    (clk),
      .rst    (rst),
      .fill   (fire),
      .out_ack(out_ack),
      .out_req(out_req)
   );

   // R4: with no flush pending, a held request keeps its acknowledge
   for (genvar i = 0; i < N_IN; i++) begin : g_chk
      p_hold_ack_r4: assert property (@(posedge clk) disable iff (rst)
         (mode == FM_NONE && in_req[i] && in_ack[i]) |=> in_ack[i]);
   end
endmodule

// File: tb/flush_coord_test.sv
module flush_coord_test;
   localparam int unsigned N_IN  = 3;
   localparam int unsigned N_OUT = 2;
   localparam int unsigned W     = 8;
   localparam int unsigned LANE  = W + 1;

   logic                   clk = 1'b0;
   logic                   rst = 1'b1;
   logic [N_IN-1:0]        in_req = '0;
   logic [N_IN*LANE-1:0]   in_bus = '0;
   logic [N_IN-1:0]        in_ack;
   logic [N_OUT-1:0]       out_req;
   logic [N_OUT*W-1:0]     out_word;
   logic [N_OUT-1:0]       out_ack = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   flush_coord #(.N_IN(N_IN), .N_OUT(N_OUT), .W(W), .COMBINE(0)) uut (
      .clk(clk), .rst(rst), .in_req(in_req), .in_bus(in_bus),
      .in_ack(in_ack), .out_req(out_req), .out_word(out_word), .out_ack(out_ack)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_in(input int idx, input bit req, input bit mark,
                         input logic [W-1:0] w);
      in_req[idx] = req;
      in_bus[idx*LANE +: LANE] = {mark, w};
   endtask

   task automatic chk_ack(input logic [N_IN-1:0] exp, input string tag);
      chk(in_ack == exp, tag, 32'(in_ack), 32'(exp));
   endtask

   task automatic chk_out(input logic [N_OUT-1:0] exp, input string tag);
      chk(out_req == exp, tag, 32'(out_req), 32'(exp));
   endtask

   task automatic chk_words(input logic [W-1:0] exp, input string tag);
      for (int j = 0; j < N_OUT; j++)
         chk(out_word[j*W +: W] == exp, tag, 32'(out_word[j*W +: W]), 32'(exp));
   endtask

   // Scoreboard for R10: any flush consumption must cover all inputs at once
   logic [N_IN-1:0] sb_prev_ack;
   logic [N_IN-1:0] sb_prev_fl;
   always @(negedge clk) begin
      if (rst) begin
         sb_prev_ack <= '1;
         sb_prev_fl  <= '0;
      end else begin
         logic [N_IN-1:0] rose;
         logic [N_IN-1:0] fl;
         rose = in_ack & ~sb_prev_ack;
         if (|(rose & sb_prev_fl)) begin
            chk((&sb_prev_fl) && (&rose), "R10 flush consumed alone",
                32'(rose), 32'((1 << N_IN) - 1));
         end
         for (int i = 0; i < N_IN; i++)
            fl[i] = in_req[i] & in_bus[i*LANE + W] & ~in_ack[i];
         sb_prev_fl  <= fl;
         sb_prev_ack <= in_ack;
      end
   end

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk_ack('1, "R2 input ack after reset");
      chk_out('0, "R2 output req after reset");
      rst = 1'b0;
      tick();
      chk_ack('0, "R4 idle ack returns low");
   endtask

   task automatic t_data();
      set_in(0, 1, 0, 8'd10);
      set_in(1, 1, 0, 8'd20);
      set_in(2, 1, 0, 8'd30);
      tick();
      chk_ack('1, "R8 stage takes all inputs");
      chk_out('1, "R8 stage fills outputs");
      chk_words(8'd60, "R8 sum word");
      tick();
      chk_ack('1, "R4 ack held while req high");
      chk_out('1, "R9 outputs still occupied");
      in_req  = '0;
      out_ack = '1;
      tick();
      chk_ack('0, "R4 ack clears after req drop");
      chk_out('0, "R7 outputs clear on ack");
      out_ack = '0;
      tick();
   endtask

   task automatic t_partial_data();
      set_in(0, 1, 0, 8'd1);
      set_in(1, 1, 0, 8'd2);
      set_in(2, 0, 0, 8'd3);
      tick();
      tick();
      chk_ack('0, "R8 no fire with missing input");
      chk_out('0, "R8 no fill with missing input");
      in_req = '0;
      tick();
   endtask

   task automatic t_flush_all();
      for (int i = 0; i < N_IN; i++) set_in(i, 1, 1, 8'(i + 5));
      tick();
      chk_ack('1, "R3 all flush tokens taken together");
      chk_out('0, "R1 flush tokens not treated as data");
      tick();
      chk_ack('1, "R4 ack held after flush");
      in_req = '0;
      tick();
      chk_ack('0, "R4 ack clears after flush round");
   endtask

   task automatic t_partial_flush();
      set_in(0, 1, 1, 8'd0);
      set_in(1, 1, 0, 8'd77);
      set_in(2, 0, 0, 8'd0);
      tick();
      chk_ack(3'b010, "R5 data input drained, flush input held");
      tick();
      chk_ack(3'b010, "R5 flush input still held");
      chk_out('0, "R1 drained data not forwarded");
      set_in(1, 0, 0, 8'd0);
      set_in(2, 1, 1, 8'd0);
      tick();
      chk_ack(3'b000, "R6 idle input ack cleared during partial flush");
      set_in(1, 1, 1, 8'd0);
      tick();
      chk_ack('1, "R3 late flush releases every input");
      in_req = '0;
      tick();
      chk_ack('0, "R4 ack clears after staggered flush");
   endtask

   task automatic t_backpressure();
      set_in(0, 1, 0, 8'd1);
      set_in(1, 1, 0, 8'd2);
      set_in(2, 1, 0, 8'd3);
      tick();
      chk_words(8'd6, "R8 first word");
      in_req = '0;
      tick();
      chk_ack('0, "R4 ack clears");
      for (int i = 0; i < N_IN; i++) set_in(i, 1, 0, 8'd100);
      tick();
      chk_ack('0, "R9 inputs wait for free outputs");
      chk_out('1, "R9 outputs still full");
      chk_words(8'd6, "R9 word unchanged");
      out_ack = 2'b01;
      tick();
      chk_out(2'b10, "R7 only acknowledged output clears");
      out_ack = 2'b10;
      tick();
      chk_out(2'b00, "R7 second output clears");
      chk_ack('0, "R9 no fire while clearing");
      out_ack = 2'b00;
      tick();
      chk_ack('1, "R8 fire once outputs free");
      chk_words(8'd44, "R8 sum wraps modulo 2^W");
      in_req  = '0;
      out_ack = '1;
      tick();
      out_ack = '0;
      tick();
   endtask

   initial begin
      t_reset();
      t_data();
      t_partial_data();
      t_flush_all();
      t_partial_flush();
      t_backpressure();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule